// File: doc/BRIEF.md
# Opcode-Driven 16-bit Arithmetic Logic Unit

This block is the arithmetic and logic engine of a small register-based processor. Each cycle it takes two data operands, a 5-bit operation code and a 4-bit position count. It computes one result, which is captured in an output register. A single carry bit lives next to the result register. Arithmetic operations write a carry or borrow into it, and the two rotate-through-carry operations both read it and write it back.

The supported operations are:

- add, subtract, multiply (low half of the product);
- bitwise AND, OR, XOR and NOT;
- plain rotates in either direction;
- 17-bit rotates through the carry in either direction;
- zero-filling shifts in either direction;
- increment and decrement.

The result is meant to be written into a register array on the following cycle. Opcode 00000 and every opcode above 01111 act as idle codes. They let the carry bit rest between operations.

Top module: `alu16_core`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o` becomes 0 and `carry_o` becomes 0.
- R2: Opcode 00001 (add) yields `res_o = a_i + b_i` modulo 2^16, with `carry_o` set to the carry out of bit 15.
- R3: Opcode 00010 (subtract) yields `res_o = a_i - b_i` modulo 2^16, with `carry_o` set to 1 exactly when `a_i < b_i` (borrow).
- R4: Opcode 00011 (multiply) yields the low 16 bits of the unsigned product `a_i * b_i` and leaves `carry_o` unchanged.
- R5: Opcodes 00100 (AND), 00101 (OR), 00111 (XOR) and 00110 (NOT of `a_i`) yield the bitwise result and leave `carry_o` unchanged.
- R6: Opcodes 01000 (rotate left) and 01001 (rotate right) rotate `a_i` by `cnt_i` positions and leave `carry_o` unchanged.
- R7: Opcodes 01010 and 01011 rotate the 17-bit ring `{carry, a_i}` left or right by `cnt_i` positions. The low 16 ring bits go to `res_o` and the top ring bit goes to `carry_o`.
- R8: Opcodes 01100 (shift left) and 01101 (shift right) shift `a_i` by `cnt_i` positions, fill with zeros and leave `carry_o` unchanged. A count of zero on any rotate or shift returns `a_i` unchanged.
- R9: Opcode 01110 yields `a_i + 1`, with carry set on wrap from 0xFFFF. Opcode 01111 yields `a_i - 1`, with carry set as a borrow when `a_i` is 0.
- R10: Opcode 00000 and opcodes 10000 to 11111 yield `res_o = 0` and leave `carry_o` unchanged.
- R11: Both outputs change only at a rising clock edge. They reflect the inputs present at that edge, so a result appears one cycle after its stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Operation code |
| a_i | input | 16 | First operand (only operand for unary, shift and rotate codes) |
| b_i | input | 16 | Second operand |
| cnt_i | input | 4 | Bit positions for rotates and shifts |
| res_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered carry / borrow flag |

## Verification
Every result and every carry update is due exactly one rising edge after its opcode and operands are applied. The bench therefore changes inputs on the falling edge and samples both outputs on the next falling edge, after exactly one register stage.

Vectors are walked back to back without idle cycles, so each expected carry follows from the carry that the previous vector left behind. The carry chain of the rotate-through-carry codes is checked this way.

A directed check samples the outputs in the same half cycle in which new inputs were applied. This confirms that nothing passes through to the outputs before the edge.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 5'b00000,
    OP_ADD  = 5'b00001,
    OP_SUB  = 5'b00010,
    OP_MUL  = 5'b00011,
    OP_AND  = 5'b00100,
    OP_OR   = 5'b00101,
    OP_NOT  = 5'b00110,
    OP_XOR  = 5'b00111,
    OP_ROL  = 5'b01000,
    OP_ROR  = 5'b01001,
    OP_RLC  = 5'b01010,
    OP_RRC  = 5'b01011,
    OP_SHL  = 5'b01100,
    OP_SHR  = 5'b01101,
    OP_INC  = 5'b01110,
    OP_DEC  = 5'b01111
  } alu_op_e;

  typedef enum logic [1:0] {
    CL_NONE,
    CL_ARITH,
    CL_LOGIC,
    CL_SHIFT
  } op_class_e;

  function automatic op_class_e op_class(input logic [OP_W-1:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_INC, OP_DEC:                 return CL_ARITH;
      OP_AND, OP_OR, OP_NOT, OP_XOR:                          return CL_LOGIC;
      OP_ROL, OP_ROR, OP_RLC, OP_RRC, OP_SHL, OP_SHR:         return CL_SHIFT;
      default:                                                return CL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           c_nxt,
  output logic           c_we
);
  logic [W:0]     sum, diff, incr, decr;
  logic [2*W-1:0] prod;

  assign sum  = {1'b0, a} + {1'b0, b};
  assign diff = {1'b0, a} - {1'b0, b};
  assign incr = {1'b0, a} + {{W{1'b0}}, 1'b1};
  assign decr = {1'b0, a} - {{W{1'b0}}, 1'b1};
  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  always_comb begin
    res   = '0;
    c_nxt = 1'b0;
    c_we  = 1'b0;
    case (op)
      OP_ADD: begin res = sum[W-1:0];  c_nxt = sum[W];  c_we = 1'b1; end
      OP_SUB: begin res = diff[W-1:0]; c_nxt = diff[W]; c_we = 1'b1; end
      OP_INC: begin res = incr[W-1:0]; c_nxt = incr[W]; c_we = 1'b1; end
      OP_DEC: begin res = decr[W-1:0]; c_nxt = decr[W]; c_we = 1'b1; end
      OP_MUL: res = prod[W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [CW-1:0]  cnt,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output logic           c_nxt,
  output logic           c_we
);
  localparam int unsigned R  = W + 1;
  localparam int unsigned AW = CW + 2;
  localparam logic [AW-1:0] W_L = AW'(W);
  localparam logic [AW-1:0] R_L = AW'(R);

  logic [AW-1:0]  n;
  logic [2*W-1:0] dbl, rol_w, ror_w;
  logic [2*R-1:0] ring2, rlc_w, rrc_w;

  assign n     = {2'b00, cnt};
  assign dbl   = {a, a};
  assign ring2 = {c_in, a, c_in, a};
  assign rol_w = dbl >> (W_L - n);
  assign ror_w = dbl >> n;
  assign rlc_w = ring2 >> (R_L - n);
  assign rrc_w = ring2 >> n;

  always_comb begin
    res   = '0;
    c_nxt = c_in;
    c_we  = 1'b0;
    case (op)
      OP_ROL: res = rol_w[W-1:0];
      OP_ROR: res = ror_w[W-1:0];
      OP_SHL: res = a << n;
      OP_SHR: res = a >> n;
      OP_RLC: begin res = rlc_w[W-1:0]; c_nxt = rlc_w[W]; c_we = 1'b1; end
      OP_RRC: begin res = rrc_w[W-1:0]; c_nxt = rrc_w[W]; c_we = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o
);
  alu_op_e   op;
  op_class_e cls;
  logic [W-1:0] ar_res, lg_res, sh_res, res_nxt;
  logic ar_c, ar_we, sh_c, sh_we, c_nxt, c_we;

  assign op  = alu_op_e'(op_i);
  assign cls = op_class(op_i);

  alu16_arith #(.W(W)) u_arith (
    .op(op), .a(a_i), .b(b_i), .res(ar_res), .c_nxt(ar_c), .c_we(ar_we)
  );

  alu16_logic #(.W(W)) u_logic (
    .op(op), .a(a_i), .b(b_i), .res(lg_res)
  );

  alu16_shift #(.W(W), .CW(CW)) u_shift (
    .op(op), .a(a_i), .cnt(cnt_i), .c_in(carry_o),
    .res(sh_res), .c_nxt(sh_c), .c_we(sh_we)
  );

  always_comb begin
    res_nxt = '0;
    c_nxt   = carry_o;
    c_we    = 1'b0;
    case (cls)
      CL_ARITH: begin res_nxt = ar_res; c_nxt = ar_c; c_we = ar_we; end
      CL_LOGIC: res_nxt = lg_res;
      CL_SHIFT: begin res_nxt = sh_res; c_nxt = sh_c; c_we = sh_we; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      res_o <= res_nxt;
      if (c_we) carry_o <= c_nxt;
    end
  end

  // R1: reset clears both registers
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !carry_o));

  // R2: add result and carry out together form the 17-bit sum
  a_r2_add_sum: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> ({carry_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  // R5: bitwise codes leave carry alone
  a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_LOGIC) |=> $stable(carry_o));

  // R7: one-position left rotate through carry
  a_r7_rlc_one: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RLC && cnt_i == CW'(1)) |=>
      (res_o == {$past(a_i[W-2:0]), $past(carry_o)} && carry_o == $past(a_i[W-1])));

  // R8: zero count on plain rotates and shifts is identity
  a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_ROL || op_i == OP_ROR || op_i == OP_SHL || op_i == OP_SHR) && cnt_i == '0)
      |=> (res_o == $past(a_i)));

  // R9: decrement of zero wraps and flags a borrow
  a_r9_dec_borrow: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DEC && a_i == '0) |=> (carry_o && res_o == '1));

  // R10: idle codes give zero and hold carry
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_NONE) |=> (res_o == '0 && $stable(carry_o)));

endmodule

// File: tb/test_alu16_core.sv
module test_alu16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [3:0]  cnt_i = '0;
  logic [15:0] res_o;
  logic        carry_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  alu16_core i_alu16_core (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .cnt_i(cnt_i), .res_o(res_o), .carry_o(carry_o)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [3:0]  cnt;
    logic [15:0] er;
    logic        ec;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{5'h01, 16'h1234, 16'h1111, 4'd0, 16'h2345, 1'b0},
    '{5'h01, 16'hFFFF, 16'h0001, 4'd0, 16'h0000, 1'b1},
    '{5'h04, 16'hF0F0, 16'h0FF0, 4'd0, 16'h00F0, 1'b1},
    '{5'h05, 16'hF000, 16'h000F, 4'd0, 16'hF00F, 1'b1},
    '{5'h07, 16'hAAAA, 16'hFFFF, 4'd0, 16'h5555, 1'b1},
    '{5'h06, 16'h00FF, 16'h1234, 4'd0, 16'hFF00, 1'b1},
    '{5'h03, 16'h0100, 16'h0100, 4'd0, 16'h0000, 1'b1},
    '{5'h03, 16'h0012, 16'h0034, 4'd0, 16'h03A8, 1'b1},
    '{5'h02, 16'h0005, 16'h0003, 4'd0, 16'h0002, 1'b0},
    '{5'h02, 16'h0003, 16'h0005, 4'd0, 16'hFFFE, 1'b1},
    '{5'h08, 16'h8001, 16'h0000, 4'd1, 16'h0003, 1'b1},
    '{5'h09, 16'h8001, 16'h0000, 4'd4, 16'h1800, 1'b1},
    '{5'h0A, 16'h8000, 16'h0000, 4'd1, 16'h0001, 1'b1},
    '{5'h0A, 16'h0001, 16'h0000, 4'd2, 16'h0006, 1'b0},
    '{5'h0B, 16'h0001, 16'h0000, 4'd1, 16'h0000, 1'b1},
    '{5'h0B, 16'h0000, 16'h0000, 4'd3, 16'h2000, 1'b0},
    '{5'h0C, 16'h8421, 16'h0000, 4'd4, 16'h4210, 1'b0},
    '{5'h0D, 16'h8421, 16'h0000, 4'd4, 16'h0842, 1'b0},
    '{5'h0C, 16'h1234, 16'h0000, 4'd0, 16'h1234, 1'b0},
    '{5'h0E, 16'hFFFF, 16'h0000, 4'd0, 16'h0000, 1'b1},
    '{5'h0E, 16'h0041, 16'h0000, 4'd0, 16'h0042, 1'b0},
    '{5'h0F, 16'h0000, 16'h0000, 4'd0, 16'hFFFF, 1'b1},
    '{5'h0F, 16'h0010, 16'h0000, 4'd0, 16'h000F, 1'b0},
    '{5'h1F, 16'h5555, 16'h5555, 4'd0, 16'h0000, 1'b0},
    '{5'h08, 16'h0001, 16'h0000, 4'd15, 16'h8000, 1'b0},
    '{5'h00, 16'hFFFF, 16'hFFFF, 4'd7, 16'h0000, 1'b0}
  };

  function automatic string req_of(input logic [4:0] op, input logic [3:0] cnt);
    if (op == 5'h01) return "R2";
    if (op == 5'h02) return "R3";
    if (op == 5'h03) return "R4";
    if (op >= 5'h04 && op <= 5'h07) return "R5";
    if ((op == 5'h08 || op == 5'h09) && cnt != 4'd0) return "R6";
    if (op == 5'h0A || op == 5'h0B) return "R7";
    if (op >= 5'h08 && op <= 5'h0D) return "R8";
    if (op == 5'h0E || op == 5'h0F) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [15:0] er, input logic ec);
    n_chk++;
    if (res_o !== er || carry_o !== ec) begin
      n_bad++;
      $display("FAIL %s: res=%h carry=%b, expected res=%h carry=%b", req, res_o, carry_o, er, ec);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [3:0] cnt);
    op_i = op; a_i = a; b_i = b; cnt_i = cnt;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", 16'h0000, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cnt);
      check(req_of(VECS[i].op, VECS[i].cnt), VECS[i].er, VECS[i].ec);
    end

    // R10: idle code keeps a set carry
    apply(5'h01, 16'hFFFF, 16'h0002, 4'd0);
    check("R2", 16'h0001, 1'b1);
    apply(5'h10, 16'h1234, 16'h1234, 4'd0);
    check("R10", 16'h0000, 1'b1);

    // R11: new inputs do not reach the outputs before the edge
    op_i = 5'h06; a_i = 16'h0F0F;
    #1;
    check("R11", 16'h0000, 1'b1);
    @(negedge clk);
    check("R11", 16'hF0F0, 1'b1);

    // R7: right rotate by zero keeps ring intact
    apply(5'h0B, 16'hBEEF, 16'h0000, 4'd0);
    check("R7", 16'hBEEF, 1'b1);

    // R1: reset in mid-stream clears a set carry and result
    rst = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000, 1'b0);
    rst = 1'b0;
    apply(5'h0E, 16'h7FFF, 16'h0000, 4'd0);
    check("R9", 16'h8000, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule